// File: doc/BRIEF.md
# Page-Mode Video Memory Controller with Display Prefetch and Write Posting

This block sits between a display scanout engine, a host bus and a page-mode DRAM. Scanout reads from a prefetch queue. The controller keeps that queue topped up with reads from sequential addresses, so successive fetches land in the row that is already open. Host writes go into a small posting queue and are acknowledged as soon as they are queued. The controller later drains them to memory, and runs entries back to back while each one follows its predecessor in the same row. Host reads are not buffered. Each one holds the host until the word arrives from memory.

The memory side is a one-command-per-cycle interface: open a row, read or write a column, or precharge. A burst, meaning a run of column accesses without a new row open, continues only while the same requester keeps presenting the next sequential address inside the open row. A change of requester, a non-consecutive address or crossing into the next row ends the burst. The controller then precharges and opens the needed row. When the display queue falls below a low-water mark, scanout fetches take absolute priority. A host read whose address is still waiting in the posting queue waits until those writes have reached memory. A host read to any other address is served ahead of the posted writes.

Top module: `vidmem_pager`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `mem_cmd` is 0 (no operation), `h_ack` is 0 and `disp_level` is 0.
- R2: Words popped from the display port come out in address order starting at word address 0, one word per pop. `disp_data` holds the popped word from the cycle after `disp_pop` is sampled. `disp_level` never exceeds the display queue depth.
- R3: A host write (`h_req`=1, `h_we`=1) accepted while the posting queue has space is acknowledged by `h_ack`=1 in the following cycle. Its data later reaches the memory word at `h_addr`.
- R4: Posted writes to consecutive word addresses within one row are issued as a single burst: one row open (`mem_cmd`=1) followed only by writes (`mem_cmd`=3), with no precharge between them.
- R5: A write burst ends at a non-consecutive address or at a row boundary. The row number is the upper bits of the word address, above the COL_W column bits. The controller then issues a precharge (`mem_cmd`=4) followed by a row open, and only after that the next write.
- R6: A row open is only issued when no row is open. A read (`mem_cmd`=2) or write is only issued while a row is open, and `mem_row` equals the open row.
- R7: When the requester changes (display fetch, host read or posted-write drain), the controller precharges and reopens the row before serving the new requester, even if it is the same row.
- R8: A host read to an address that still has a posted write pending returns the newly written data, not the older memory contents.
- R9: A host read to an address with no pending posted write is issued to memory before the posted writes still waiting in the queue.
- R10: While the posting queue is full, a host write is held without acknowledgement until an entry drains. No write is lost.
- R11: While the display queue level plus its outstanding fetches is below LOW_MARK, no posted write and no host read is issued. After reset, at least LOW_MARK display reads precede the first memory write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_pop | input | 1 | Scanout takes one word from the display queue (ignored when empty) |
| disp_data | output | DW | Word taken by the last accepted pop |
| disp_level | output | $clog2(DISP_DEPTH+1) | Words held in the display queue |
| h_req | input | 1 | Host request; the host changes or drops it in the cycle `h_ack` is high |
| h_we | input | 1 | 1 = write, 0 = read |
| h_addr | input | AW | Host word address |
| h_wdata | input | DW | Host write data |
| h_ack | output | 1 | One-cycle acknowledge: write queued, or read data valid |
| h_rdata | output | DW | Host read data, valid while `h_ack` answers a read |
| mem_cmd | output | 3 | 0 none, 1 row open, 2 read, 3 write, 4 precharge |
| mem_row | output | AW-COL_W | Row for row open, read and write |
| mem_col | output | COL_W | Column for read and write |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data returned by memory, in issue order |
| mem_rvalid | input | 1 | `mem_rdata` holds the next returned read word |

## Verification
The bench builds the controller with 8-bit word addresses and 16-column rows, so a write run crosses a row boundary in a handful of writes. The posting queue is 4 deep. A stream of writes scattered over different rows costs three memory commands each, so it fills the queue and brings the host wait state and the read-bypass and read-after-write orderings into reach. An 8-deep display queue with a low-water mark of 3 lets the bench observe urgent fetches winning over a write posted right after reset, and a full queue that leaves the memory free for host-only command sequences.

// File: rtl/vmp_pkg.sv
package vmp_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4
  } mem_cmd_e;

  typedef enum logic [1:0] {
    SRC_DISP = 2'd0,
    SRC_HRD  = 2'd1,
    SRC_POST = 2'd2
  } src_e;
endpackage

// File: rtl/vmp_disp_fifo.sv
module vmp_disp_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  localparam int PW = $clog2(DEPTH),
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] pop_data,
  output logic [LW-1:0] level
);
  logic [DW-1:0] store [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [LW-1:0] lvl_q;
  logic [DW-1:0] out_q;
  logic          do_push, do_pop;

  assign do_push = push && (lvl_q != LW'(DEPTH));
  assign do_pop  = pop && (lvl_q != '0);

  always_ff @(posedge clk) begin
    if (do_push) store[wp_q] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst)         out_q <= '0;
    else if (do_pop) out_q <= store[rp_q];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q  <= '0;
      rp_q  <= '0;
      lvl_q <= '0;
    end else begin
      if (do_push) wp_q <= wp_q + PW'(1);
      if (do_pop)  rp_q <= rp_q + PW'(1);
      lvl_q <= lvl_q + LW'(do_push) - LW'(do_pop);
    end
  end

  assign pop_data = out_q;
  assign level    = lvl_q;
endmodule

// File: rtl/vmp_post_fifo.sv
module vmp_post_fifo #(
  parameter int AW    = 8,
  parameter int DW    = 16,
  parameter int DEPTH = 4,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [AW-1:0] head_addr,
  output logic [DW-1:0] head_data,
  output logic          empty,
  output logic          full,
  input  logic [AW-1:0] probe_addr,
  output logic          probe_hit
);
  logic [AW-1:0]    addr_q [DEPTH];
  logic [DW-1:0]    data_m [DEPTH];
  logic [DEPTH-1:0] vld_q;
  logic [DEPTH-1:0] hitv;
  logic [PW-1:0]    wp_q, rp_q;
  logic [CW-1:0]    cnt_q;
  logic             do_push, do_pop;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  always_ff @(posedge clk) begin
    if (do_push) begin
      data_m[wp_q] <= push_data;
      addr_q[wp_q] <= push_addr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      vld_q <= '0;
    end else begin
      if (do_push) begin
        wp_q        <= wp_q + PW'(1);
        vld_q[wp_q] <= 1'b1;
      end
      if (do_pop) begin
        rp_q        <= rp_q + PW'(1);
        vld_q[rp_q] <= 1'b0;
      end
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_probe
    assign hitv[g] = vld_q[g] && (addr_q[g] == probe_addr);
  end

  assign probe_hit = |hitv;
  assign head_addr = addr_q[rp_q];
  assign head_data = data_m[rp_q];
endmodule

// File: rtl/vmp_sched.sv
module vmp_sched
  import vmp_pkg::*;
#(
  parameter int AW        = 8,
  parameter int COL_W     = 4,
  parameter int DW        = 16,
  parameter int DD        = 8,
  parameter int RQ        = 4,
  parameter int LOW_MARK  = 3,
  localparam int RW = AW - COL_W,
  localparam int LW = $clog2(DD + 1),
  localparam int QW = $clog2(RQ),
  localparam int IW = $clog2(RQ + 1),
  localparam int SW = LW + IW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [LW-1:0] disp_level,
  input  logic          host_rd_pend,
  input  logic [AW-1:0] host_addr,
  input  logic          rd_hit,
  input  logic          wf_empty,
  input  logic [AW-1:0] wf_addr,
  input  logic [DW-1:0] wf_data,
  input  logic          mem_rvalid,
  output logic          urgent,
  output logic          wf_pop,
  output logic          host_issue,
  output logic          ret_disp,
  output logic          ret_host,
  output logic [2:0]    mem_cmd,
  output logic [RW-1:0] mem_row,
  output logic [COL_W-1:0] mem_col,
  output logic [DW-1:0] mem_wdata
);
  // row and burst tracking
  logic          open_q;
  logic [RW-1:0] row_q;
  src_e          last_src_q;
  logic [AW-1:0] next_q;
  logic [AW-1:0] disp_addr_q;

  // read-return tag queue (1 = host read)
  logic          tq_m [RQ];
  logic [QW-1:0] tq_wp_q, tq_rp_q;
  logic [IW-1:0] tq_cnt_q, infl_q;
  logic          tq_full;

  // registered command outputs
  mem_cmd_e         cmd_q;
  logic [RW-1:0]    mrow_q;
  logic [COL_W-1:0] mcol_q;
  logic [DW-1:0]    mwd_q;

  logic [SW-1:0] demand;
  logic          room, go, is_wr, hit, fire, disp_issue, issue_rd;
  src_e          src;
  logic [AW-1:0] tgt;
  logic [RW-1:0] tgt_row;
  mem_cmd_e      cmd_n;

  assign demand  = SW'(disp_level) + SW'(infl_q);
  assign urgent  = demand < SW'(LOW_MARK);
  assign room    = demand < SW'(DD);
  assign tq_full = (tq_cnt_q == IW'(RQ));

  // requester selection: urgent scanout, host read, write drain, background fill
  always_comb begin
    go    = 1'b0;
    src   = SRC_DISP;
    tgt   = disp_addr_q;
    is_wr = 1'b0;
    if (urgent) begin
      go = !tq_full;
    end else if (host_rd_pend && !rd_hit && !tq_full) begin
      go  = 1'b1;
      src = SRC_HRD;
      tgt = host_addr;
    end else if (!wf_empty) begin
      go    = 1'b1;
      src   = SRC_POST;
      tgt   = wf_addr;
      is_wr = 1'b1;
    end else if (room && !tq_full) begin
      go = 1'b1;
    end
  end

  assign tgt_row = tgt[AW-1:COL_W];
  assign hit     = open_q && (last_src_q == src) && (tgt == next_q) && (tgt_row == row_q);

  always_comb begin
    if (!go)        cmd_n = CMD_NOP;
    else if (hit)   cmd_n = is_wr ? CMD_WR : CMD_RD;
    else if (open_q) cmd_n = CMD_PRE;
    else            cmd_n = CMD_ACT;
  end

  assign fire       = go && hit;
  assign disp_issue = fire && (src == SRC_DISP);
  assign host_issue = fire && (src == SRC_HRD);
  assign wf_pop     = fire && is_wr;
  assign issue_rd   = disp_issue || host_issue;
  assign ret_host   = mem_rvalid && tq_m[tq_rp_q];
  assign ret_disp   = mem_rvalid && !tq_m[tq_rp_q];

  always_ff @(posedge clk) begin
    if (issue_rd) tq_m[tq_wp_q] <= host_issue;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q      <= 1'b0;
      row_q       <= '0;
      last_src_q  <= SRC_DISP;
      next_q      <= '0;
      disp_addr_q <= '0;
      tq_wp_q     <= '0;
      tq_rp_q     <= '0;
      tq_cnt_q    <= '0;
      infl_q      <= '0;
      cmd_q       <= CMD_NOP;
      mrow_q      <= '0;
      mcol_q      <= '0;
      mwd_q       <= '0;
    end else begin
      cmd_q  <= cmd_n;
      mrow_q <= tgt_row;
      mcol_q <= tgt[COL_W-1:0];
      if (wf_pop) mwd_q <= wf_data;
      case (cmd_n)
        CMD_ACT: begin
          open_q     <= 1'b1;
          row_q      <= tgt_row;
          last_src_q <= src;
          next_q     <= tgt;
        end
        CMD_PRE: open_q <= 1'b0;
        CMD_RD, CMD_WR: next_q <= tgt + AW'(1);
        default: ;
      endcase
      if (disp_issue) disp_addr_q <= disp_addr_q + AW'(1);
      if (issue_rd)   tq_wp_q <= tq_wp_q + QW'(1);
      if (mem_rvalid) tq_rp_q <= tq_rp_q + QW'(1);
      tq_cnt_q <= tq_cnt_q + IW'(issue_rd) - IW'(mem_rvalid);
      infl_q   <= infl_q + IW'(disp_issue) - IW'(ret_disp);
    end
  end

  assign mem_cmd   = cmd_q;
  assign mem_row   = mrow_q;
  assign mem_col   = mcol_q;
  assign mem_wdata = mwd_q;
endmodule

// File: rtl/vidmem_pager.sv
module vidmem_pager #(
  parameter int AW         = 8,
  parameter int COL_W      = 4,
  parameter int DW         = 16,
  parameter int DISP_DEPTH = 8,
  parameter int POST_DEPTH = 4,
  parameter int RD_QUEUE   = 4,
  parameter int LOW_MARK   = 3,
  localparam int RW = AW - COL_W,
  localparam int LW = $clog2(DISP_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             disp_pop,
  output logic [DW-1:0]    disp_data,
  output logic [LW-1:0]    disp_level,
  input  logic             h_req,
  input  logic             h_we,
  input  logic [AW-1:0]    h_addr,
  input  logic [DW-1:0]    h_wdata,
  output logic             h_ack,
  output logic [DW-1:0]    h_rdata,
  output logic [2:0]       mem_cmd,
  output logic [RW-1:0]    mem_row,
  output logic [COL_W-1:0] mem_col,
  output logic [DW-1:0]    mem_wdata,
  input  logic [DW-1:0]    mem_rdata,
  input  logic             mem_rvalid
);
  logic          wf_full, wf_empty, wf_pop, rd_hit;
  logic [AW-1:0] wf_addr;
  logic [DW-1:0] wf_data;
  logic          wr_accept, host_rd_pend, host_issue;
  logic          ret_disp, ret_host, urgent;
  logic          rd_busy_q, ack_q;
  logic [DW-1:0] rdata_q;

  assign wr_accept    = h_req && h_we && !wf_full;
  assign host_rd_pend = h_req && !h_we && !rd_busy_q;

  vmp_disp_fifo #(.DW(DW), .DEPTH(DISP_DEPTH)) u_disp (
    .clk       (clk),
    .rst       (rst),
    .push      (ret_disp),
    .push_data (mem_rdata),
    .pop       (disp_pop),
    .pop_data  (disp_data),
    .level     (disp_level)
  );

  vmp_post_fifo #(.AW(AW), .DW(DW), .DEPTH(POST_DEPTH)) u_post (
    .clk        (clk),
    .rst        (rst),
    .push       (wr_accept),
    .push_addr  (h_addr),
    .push_data  (h_wdata),
    .pop        (wf_pop),
    .head_addr  (wf_addr),
    .head_data  (wf_data),
    .empty      (wf_empty),
    .full       (wf_full),
    .probe_addr (h_addr),
    .probe_hit  (rd_hit)
  );

  vmp_sched #(
    .AW(AW), .COL_W(COL_W), .DW(DW), .DD(DISP_DEPTH),
    .RQ(RD_QUEUE), .LOW_MARK(LOW_MARK)
  ) u_sched (
    .clk          (clk),
    .rst          (rst),
    .disp_level   (disp_level),
    .host_rd_pend (host_rd_pend),
    .host_addr    (h_addr),
    .rd_hit       (rd_hit),
    .wf_empty     (wf_empty),
    .wf_addr      (wf_addr),
    .wf_data      (wf_data),
    .mem_rvalid   (mem_rvalid),
    .urgent       (urgent),
    .wf_pop       (wf_pop),
    .host_issue   (host_issue),
    .ret_disp     (ret_disp),
    .ret_host     (ret_host),
    .mem_cmd      (mem_cmd),
    .mem_row      (mem_row),
    .mem_col      (mem_col),
    .mem_wdata    (mem_wdata)
  );

  // host port: write acknowledge on queueing, read acknowledge on data return
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_busy_q <= 1'b0;
      ack_q     <= 1'b0;
      rdata_q   <= '0;
    end else begin
      ack_q <= wr_accept || ret_host;
      if (host_issue)    rd_busy_q <= 1'b1;
      else if (ret_host) rd_busy_q <= 1'b0;
      if (ret_host) rdata_q <= mem_rdata;
    end
  end

  assign h_ack   = ack_q;
  assign h_rdata = rdata_q;
endmodule

// File: rtl/vmp_chk.sv
module vmp_chk
  import vmp_pkg::*;
#(
  parameter int RW = 4,
  parameter int DD = 8,
  parameter int LW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic [2:0]    mem_cmd,
  input logic [RW-1:0] mem_row,
  input logic [LW-1:0] disp_level,
  input logic          h_req,
  input logic          h_we,
  input logic          h_ack,
  input logic          wf_full,
  input logic          wf_pop,
  input logic          urgent,
  input logic          host_issue,
  input logic          host_rd_pend,
  input logic          rd_hit
);
  logic          ck_open;
  logic [RW-1:0] ck_row;

  always_ff @(posedge clk) begin
    if (rst) begin
      ck_open <= 1'b0;
      ck_row  <= '0;
    end else if (mem_cmd == CMD_ACT) begin
      ck_open <= 1'b1;
      ck_row  <= mem_row;
    end else if (mem_cmd == CMD_PRE) begin
      ck_open <= 1'b0;
    end
  end

  // R6
  act_closed_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_cmd == CMD_ACT) |-> !ck_open);

  // R6
  access_open_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_cmd == CMD_RD || mem_cmd == CMD_WR) |-> (ck_open && mem_row == ck_row));

  // R10
  full_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (h_req && h_we && wf_full) |=> !h_ack);

  // R11
  urgent_first_chk: assert property (@(posedge clk) disable iff (rst)
    urgent |-> (!wf_pop && !host_issue));

  // R8
  no_stale_chk: assert property (@(posedge clk) disable iff (rst)
    (host_rd_pend && rd_hit) |-> !host_issue);

  // R2
  level_bound_chk: assert property (@(posedge clk) disable iff (rst)
    disp_level <= LW'(DD));
endmodule

bind vidmem_pager vmp_chk #(.RW(RW), .DD(DISP_DEPTH), .LW(LW)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .mem_cmd      (mem_cmd),
  .mem_row      (mem_row),
  .disp_level   (disp_level),
  .h_req        (h_req),
  .h_we         (h_we),
  .h_ack        (h_ack),
  .wf_full      (wf_full),
  .wf_pop       (wf_pop),
  .urgent       (urgent),
  .host_issue   (host_issue),
  .host_rd_pend (host_rd_pend),
  .rd_hit       (rd_hit)
);

// File: tb/sim_vidmem_pager.sv
module sim_vidmem_pager;
  localparam int AW = 8, COL_W = 4, DW = 16, DD = 8, WD = 4, RQ = 4, LOW = 3;
  localparam int RW = AW - COL_W;
  localparam int LW = $clog2(DD + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic disp_pop = 1'b0;
  logic [DW-1:0] disp_data;
  logic [LW-1:0] disp_level;
  logic h_req = 1'b0, h_we = 1'b0;
  logic [AW-1:0] h_addr = '0;
  logic [DW-1:0] h_wdata = '0;
  logic h_ack;
  logic [DW-1:0] h_rdata;
  logic [2:0] mem_cmd;
  logic [RW-1:0] mem_row;
  logic [COL_W-1:0] mem_col;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata;
  logic mem_rvalid;

  always #10 clk = ~clk;  // 50 MHz

  vidmem_pager #(
    .AW(AW), .COL_W(COL_W), .DW(DW), .DISP_DEPTH(DD),
    .POST_DEPTH(WD), .RD_QUEUE(RQ), .LOW_MARK(LOW)
  ) u0 (
    .clk(clk), .rst(rst), .disp_pop(disp_pop), .disp_data(disp_data),
    .disp_level(disp_level), .h_req(h_req), .h_we(h_we), .h_addr(h_addr),
    .h_wdata(h_wdata), .h_ack(h_ack), .h_rdata(h_rdata), .mem_cmd(mem_cmd),
    .mem_row(mem_row), .mem_col(mem_col), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid)
  );

  int checks = 0, fails = 0;
  bit done = 1'b0;

  function automatic logic [DW-1:0] fval(input int a);
    logic [7:0] b;
    b = 8'(a);
    return {b ^ 8'h5A, ~b};
  endfunction

  // memory model: latency 2, in-order returns, protocol watch
  logic [DW-1:0] mem [256];
  logic m_open;
  logic [RW-1:0] m_row;
  logic rv1;
  logic [DW-1:0] rd1;
  int proto_err = 0;
  int lg_n = 0;
  int lg_cmd [1024];
  int lg_row [1024];
  int lg_col [1024];

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) mem[i] <= fval(i);
      m_open <= 1'b0;
      m_row <= '0;
      rv1 <= 1'b0;
      rd1 <= '0;
      mem_rvalid <= 1'b0;
      mem_rdata <= '0;
    end else begin
      rv1 <= 1'b0;
      case (mem_cmd)
        3'd1: begin
          if (m_open) proto_err++;
          m_open <= 1'b1;
          m_row <= mem_row;
        end
        3'd2: begin
          if (!m_open || m_row != mem_row) proto_err++;
          rv1 <= 1'b1;
          rd1 <= mem[{mem_row, mem_col}];
        end
        3'd3: begin
          if (!m_open || m_row != mem_row) proto_err++;
          mem[{mem_row, mem_col}] <= mem_wdata;
        end
        3'd4: m_open <= 1'b0;
        default: ;
      endcase
      mem_rvalid <= rv1;
      mem_rdata <= rd1;
      if (mem_cmd != 3'd0 && lg_n < 1024) begin
        lg_cmd[lg_n] = int'(mem_cmd);
        lg_row[lg_n] = int'(mem_row);
        lg_col[lg_n] = int'(mem_col);
        lg_n++;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // row/col of -1 means don't care
  task automatic log_is(input int idx, input int cmd, input int row, input int col, input string tag);
    int enc_a, enc_e;
    enc_a = (idx < lg_n) ? (lg_cmd[idx] * 256 + (row < 0 ? 0 : lg_row[idx]) * 16 + (col < 0 ? 0 : lg_col[idx])) : -1;
    enc_e = cmd * 256 + (row < 0 ? 0 : row) * 16 + (col < 0 ? 0 : col);
    chk(enc_a == enc_e, tag, enc_a, enc_e);
  endtask

  task automatic host_write(input int a, input int d, output int waited);
    h_req = 1'b1; h_we = 1'b1; h_addr = AW'(a); h_wdata = DW'(d);
    waited = 0;
    do begin @(negedge clk); waited++; end while (!h_ack && waited < 1000);
    h_req = 1'b0;
  endtask

  task automatic host_read(input int a, output logic [DW-1:0] d);
    int w;
    h_req = 1'b1; h_we = 1'b0; h_addr = AW'(a);
    w = 0;
    do begin @(negedge clk); w++; end while (!h_ack && w < 1000);
    d = h_rdata;
    h_req = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(mem_cmd == 3'd0, "R1 mem_cmd in reset", int'(mem_cmd), 0);
    chk(h_ack == 1'b0, "R1 h_ack in reset", int'(h_ack), 0);
    chk(disp_level == '0, "R1 disp_level in reset", int'(disp_level), 0);
    rst = 1'b0;
  endtask

  task automatic t_urgent_first();
    int w, nrd, first_wr;
    host_write(8'hA0, 16'h1234, w);
    chk(w == 1, "R3 first write ack latency", w, 1);
    idle(60);
    first_wr = -1; nrd = 0;
    for (int i = 0; i < lg_n; i++) begin
      if (first_wr < 0 && lg_cmd[i] == 3) first_wr = i;
      if (first_wr < 0 && lg_cmd[i] == 2) nrd++;
    end
    chk(first_wr >= 0 && nrd >= LOW, "R11 display reads before first write", nrd, LOW);
    chk(mem[8'hA0] == 16'h1234, "R3 posted data in memory", int'(mem[8'hA0]), 16'h1234);
    chk(disp_level == LW'(DD), "R2 display queue filled", int'(disp_level), DD);
  endtask

  task automatic t_req_switch();
    int b;
    logic [DW-1:0] d;
    b = lg_n;
    host_read(9, d);
    idle(5);
    chk(d == fval(9), "R7 host read data", int'(d), int'(fval(9)));
    log_is(b, 4, -1, -1, "R7 precharge on requester change");
    log_is(b + 1, 1, 0, -1, "R7 reopen same row");
    log_is(b + 2, 2, 0, 9, "R7 host read column");
  endtask

  task automatic t_burst();
    int b, w;
    b = lg_n;
    for (int i = 0; i < 4; i++) begin
      host_write(8'h50 + i, 16'hA500 + i, w);
      chk(w == 1, "R3 write ack latency", w, 1);
    end
    idle(10);
    chk(lg_n - b == 6, "R4 command count of burst", lg_n - b, 6);
    log_is(b, 4, -1, -1, "R4 close previous row");
    log_is(b + 1, 1, 5, -1, "R4 single row open");
    for (int i = 0; i < 4; i++) begin
      log_is(b + 2 + i, 3, 5, i, "R4 burst write");
      chk(mem[8'h50 + i] == DW'(16'hA500 + i), "R3 burst data", int'(mem[8'h50 + i]), 16'hA500 + i);
    end
  endtask

  task automatic t_boundary();
    int b, w;
    b = lg_n;
    host_write(8'h6E, 16'h0E0E, w);
    host_write(8'h6F, 16'h0F0F, w);
    host_write(8'h70, 16'h7070, w);
    host_write(8'h72, 16'h7272, w);
    idle(12);
    log_is(b,     4, -1, -1, "R5 close row");
    log_is(b + 1, 1, 6, -1, "R5 open row 6");
    log_is(b + 2, 3, 6, 14, "R5 write col 14");
    log_is(b + 3, 3, 6, 15, "R5 write col 15");
    log_is(b + 4, 4, -1, -1, "R5 precharge at row boundary");
    log_is(b + 5, 1, 7, -1, "R5 open row 7");
    log_is(b + 6, 3, 7, 0, "R5 write row 7 col 0");
    log_is(b + 7, 4, -1, -1, "R5 precharge at address gap");
    log_is(b + 8, 1, 7, -1, "R5 reopen row 7");
    log_is(b + 9, 3, 7, 2, "R5 write row 7 col 2");
  endtask

  task automatic t_full_and_stale();
    int w, maxw;
    logic [DW-1:0] d;
    maxw = 0;
    for (int r = 4; r < 16; r++) begin
      host_write(r * 17, 16'hB000 + r * 17, w);
      if (w > maxw) maxw = w;
    end
    chk(maxw > 1, "R10 host held while posting queue full", maxw, 2);
    host_read(8'hFF, d);
    chk(d == 16'hB0FF, "R8 read returns posted data", int'(d), 16'hB0FF);
    idle(40);
    for (int r = 4; r < 16; r++)
      chk(mem[r * 17] == DW'(16'hB000 + r * 17), "R10 no write lost", int'(mem[r * 17]), 16'hB000 + r * 17);
  endtask

  task automatic t_bypass();
    int b, w, ri, wi;
    logic [DW-1:0] d;
    b = lg_n;
    for (int r = 4; r < 10; r++) host_write(r * 16, 16'hC000 + r, w);
    host_read(8'h21, d);
    idle(40);
    chk(d == fval(8'h21), "R9 bypass read data", int'(d), int'(fval(8'h21)));
    ri = -1; wi = -1;
    for (int i = b; i < lg_n; i++) begin
      if (lg_cmd[i] == 2 && lg_row[i] == 2 && lg_col[i] == 1) ri = i;
      if (lg_cmd[i] == 3 && lg_row[i] == 9 && lg_col[i] == 0) wi = i;
    end
    chk(ri >= 0 && wi >= 0 && ri < wi, "R9 read issued before queued write", ri, wi);
  endtask

  task automatic t_display_seq();
    for (int i = 0; i < 24; i++) begin
      int w;
      w = 0;
      while (disp_level == '0 && w < 200) begin @(negedge clk); w++; end
      disp_pop = 1'b1;
      @(negedge clk);
      disp_pop = 1'b0;
      chk(disp_data == fval(i), "R2 display word order", int'(disp_data), int'(fval(i)));
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    chk(mem_cmd == 3'd0 && h_ack == 1'b0, "R1 first cycle after reset", int'(mem_cmd), 0);
    t_urgent_first();
    t_req_switch();
    t_burst();
    t_boundary();
    t_full_and_stale();
    t_bypass();
    t_display_seq();
    idle(10);
    chk(proto_err == 0, "R6 memory command protocol", proto_err, 0);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 100000, 0);
      summary();
      $finish;
    end
  end
endmodule